// File: doc/BRIEF.md
# Descriptor Queue Accumulator with Paced Interrupt

This block drains descriptors from a set of hardware queues into a list that a host processor reads in bulk. It watches per-queue "not empty" flags, asks a queue manager to pop one descriptor at a time, and writes each returned descriptor address, tagged with the offset of the queue it came from, into consecutive slots of a list buffer. The host learns about new work through a single interrupt line instead of one event per descriptor.

The interrupt is raised either when the list holds the configured number of entries or when a pacing timer runs out, whichever comes first. Four pacing modes pick what starts the timer: nothing (full list only), the return to accumulation after the previous interrupt, the first entry of a new list, or the most recent entry. The delay is given in microsecond ticks derived from the core clock by a prescaler. The block can watch one selected queue or all queues of its group with round-robin service. After an interrupt the list is frozen until the host acknowledges it.

Top module: `qacc_channel`

## Requirements
- R1: While and directly after reset, `irq`, `pop_req` and `lst_we` are low and `lst_count` is 0; after reset the round-robin scan starts at queue offset 0.
- R2: With `cfg_multi` low only queue `cfg_single` is popped and the flags of all other queues are ignored; each list write places the queue offset in `lst_entry[DESC_W+4:DESC_W]` and the descriptor address in `lst_entry[DESC_W-1:0]`, at index `lst_idx` equal to the list count before the write, one clock after the pop response.
- R3: With `cfg_multi` high, non-empty queues are served round-robin beginning with the offset after the last one served, and at most one pop request is outstanding; `pop_req` and `pop_qsel` hold until `pop_ack`.
- R4: When a write brings `lst_count` to `cfg_list_len` (a value of 0 acts as 1), `irq` rises on the same clock edge as that write.
- R5: While `irq` is high no pop is requested and `lst_count` holds; a one-cycle `irq_ack` drops `irq` and clears `lst_count` on the next edge, and accumulation resumes.
- R6: Pacing mode 0 (`cfg_mode`=0) raises `irq` only on a full list.
- R7: Pacing mode 1 starts the timer when reset ends and at each acknowledge; `irq` rises `cfg_latency`*`TICK_DIV` cycles after the acknowledge edge if entries are present; an expiry with an empty list raises nothing and restarts the timer.
- R8: Pacing mode 2 starts the timer at the write of list entry 0; `irq` rises `cfg_latency`*`TICK_DIV` cycles after that write.
- R9: Pacing mode 3 restarts the timer at every list write; `irq` rises `cfg_latency`*`TICK_DIV` cycles after the latest write.
- R10: A `cfg_latency` of 0 behaves as 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Pacing mode 0..3 |
| cfg_multi | input | 1 | 1: scan all queues of the group, 0: one queue |
| cfg_single | input | 5 | Queue offset watched in single-queue mode |
| cfg_list_len | input | CNT_W | Entries per list before interrupt |
| cfg_latency | input | LAT_W | Pacing delay in microsecond ticks |
| q_nonempty | input | NQ | Per-queue non-empty flags |
| pop_req | output | 1 | Pop request, held until answered |
| pop_qsel | output | 5 | Queue offset to pop |
| pop_ack | input | 1 | Pop response valid |
| pop_desc | input | DESC_W | Popped descriptor address |
| lst_we | output | 1 | List buffer write strobe |
| lst_idx | output | CNT_W | List slot written |
| lst_entry | output | DESC_W+5 | Queue offset and descriptor address |
| lst_count | output | CNT_W | Entries in the current list |
| irq | output | 1 | Interrupt to host, level |
| irq_ack | input | 1 | Host acknowledge, one-cycle pulse |

## Verification
The bench builds the block with `TICK_DIV`=4 and `LIST_MAX`=16 while keeping the full group of 32 queues, so a pacing window of a few ticks lasts only tens of cycles and each mode's start event can be timed to the exact cycle. Lists of 6 entries fill quickly enough to see the full-list interrupt, the frozen list during a pending interrupt, and the round-robin order wrapping from offset 30 back to low offsets. Zero latency and zero list length are reached with the same build.

// File: rtl/qacc_pkg.sv
package qacc_pkg;
    localparam int QOFF_W = 5;

    typedef enum logic [1:0] {
        PACE_FULL_ONLY  = 2'd0,
        PACE_AFTER_ACK  = 2'd1,
        PACE_FIRST_ITEM = 2'd2,
        PACE_LAST_ITEM  = 2'd3
    } pace_mode_e;
endpackage

// File: rtl/qacc_scan.sv
// Round-robin pick: the first eligible queue after the last one served.
module qacc_scan #(
    parameter int NQ = 32
) (
    input  logic [NQ-1:0]                 elig_i,
    input  logic [qacc_pkg::QOFF_W-1:0]   last_i,
    output logic                          found_o,
    output logic [qacc_pkg::QOFF_W-1:0]   pick_o
);
    import qacc_pkg::*;

    always_comb begin
        found_o = 1'b0;
        pick_o  = last_i;
        for (int i = 1; i <= NQ; i++) begin
            int k;
            k = (int'(last_i) + i) % NQ;
            if (!found_o && elig_i[k]) begin
                found_o = 1'b1;
                pick_o  = QOFF_W'(k);
            end
        end
    end
endmodule

// File: rtl/qacc_pacer.sv
// Pacing timer: prescaler to microsecond ticks plus a tick down-counter.
module qacc_pacer #(
    parameter int LAT_W    = 16,
    parameter int TICK_DIV = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [LAT_W-1:0] latency_i,
    output logic             expire_o
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic             run;
        logic [PW-1:0]    presc;
        logic [LAT_W-1:0] cnt;
    } pace_st_t;

    pace_st_t s_q, s_d;
    logic     tick;

    always_comb begin
        tick     = s_q.run && (s_q.presc == PW'(TICK_DIV - 1));
        expire_o = tick && (s_q.cnt <= LAT_W'(1));
        s_d      = s_q;
        if (s_q.run) begin
            s_d.presc = tick ? '0 : s_q.presc + 1'b1;
        end
        if (tick) begin
            if (s_q.cnt <= LAT_W'(1)) begin
                s_d.run = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (stop_i) begin
            s_d.run = 1'b0;
        end
        if (start_i) begin
            s_d.run   = 1'b1;
            s_d.presc = '0;
            s_d.cnt   = latency_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/qacc_channel.sv
module qacc_channel #(
    parameter int NQ       = 32,
    parameter int DESC_W   = 32,
    parameter int LIST_MAX = 64,
    parameter int LAT_W    = 16,
    parameter int TICK_DIV = 100,
    localparam int CNT_W   = $clog2(LIST_MAX + 1),
    localparam int ENT_W   = DESC_W + qacc_pkg::QOFF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   cfg_mode,
    input  logic                         cfg_multi,
    input  logic [qacc_pkg::QOFF_W-1:0]  cfg_single,
    input  logic [CNT_W-1:0]             cfg_list_len,
    input  logic [LAT_W-1:0]             cfg_latency,
    input  logic [NQ-1:0]                q_nonempty,
    output logic                         pop_req,
    output logic [qacc_pkg::QOFF_W-1:0]  pop_qsel,
    input  logic                         pop_ack,
    input  logic [DESC_W-1:0]            pop_desc,
    output logic                         lst_we,
    output logic [CNT_W-1:0]             lst_idx,
    output logic [ENT_W-1:0]             lst_entry,
    output logic [CNT_W-1:0]             lst_count,
    output logic                         irq,
    input  logic                         irq_ack
);
    import qacc_pkg::*;

    typedef struct packed {
        logic              irq;
        logic [CNT_W-1:0]  count;
        logic [QOFF_W-1:0] last;
        logic              req;
        logic [QOFF_W-1:0] qsel;
        logic              we;
        logic [CNT_W-1:0]  idx;
        logic [ENT_W-1:0]  entry;
        logic              due;
        logic              boot;
    } acc_st_t;

    acc_st_t           st_q, st_d;
    logic [NQ-1:0]     elig;
    logic              found;
    logic [QOFF_W-1:0] pick;
    logic              expire;
    logic              t_start, t_stop;
    pace_mode_e        mode;

    assign mode = pace_mode_e'(cfg_mode);

    // eligibility mask: every queue in group mode, one selected queue otherwise
    for (genvar g = 0; g < NQ; g++) begin : g_elig
        assign elig[g] = q_nonempty[g] & (cfg_multi | (cfg_single == QOFF_W'(g)));
    end

    qacc_scan #(.NQ(NQ)) i_scan (
        .elig_i  (elig),
        .last_i  (st_q.last),
        .found_o (found),
        .pick_o  (pick)
    );

    qacc_pacer #(.LAT_W(LAT_W), .TICK_DIV(TICK_DIV)) i_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (t_start),
        .stop_i    (t_stop),
        .latency_i (cfg_latency),
        .expire_o  (expire)
    );

    always_comb begin
        logic             resp, busy, acked, full_now, timeout, fire, issue;
        logic [CNT_W-1:0] cnt_inc, len_eff;

        st_d     = st_q;
        resp     = st_q.req & pop_ack;
        busy     = st_q.req & ~pop_ack;
        acked    = st_q.irq & irq_ack;
        cnt_inc  = st_q.count + CNT_W'(resp);
        len_eff  = (cfg_list_len == '0) ? CNT_W'(1) : cfg_list_len;
        full_now = resp && (cnt_inc >= len_eff);
        timeout  = expire | st_q.due;
        fire     = !st_q.irq &&
                   (full_now || (timeout && !busy && (cnt_inc != '0)));
        issue    = !st_q.req && !st_q.irq && !fire && found;

        // interrupt and list count
        st_d.irq   = acked ? 1'b0 : (st_q.irq | fire);
        st_d.count = acked ? '0 : cnt_inc;
        // expiry seen while a pop is in flight waits for that response
        st_d.due   = timeout && busy && !st_q.irq;
        st_d.boot  = 1'b0;

        // list write
        st_d.we    = resp;
        st_d.idx   = st_q.count;
        st_d.entry = {st_q.qsel, pop_desc};

        // pop request
        if (resp) begin
            st_d.req = 1'b0;
        end
        if (issue) begin
            st_d.req  = 1'b1;
            st_d.qsel = pick;
            st_d.last = pick;
        end

        // pacing timer control
        t_stop = fire;
        unique case (mode)
            PACE_AFTER_ACK:  t_start = st_q.boot || acked ||
                                       (expire && !busy && !st_q.irq && (cnt_inc == '0));
            PACE_FIRST_ITEM: t_start = resp && (st_q.count == '0) && !fire;
            PACE_LAST_ITEM:  t_start = resp && !fire;
            default:         t_start = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.last <= QOFF_W'(NQ - 1);
            st_q.boot <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pop_req   = st_q.req;
    assign pop_qsel  = st_q.qsel;
    assign lst_we    = st_q.we;
    assign lst_idx   = st_q.idx;
    assign lst_entry = st_q.entry;
    assign lst_count = st_q.count;
    assign irq       = st_q.irq;
endmodule

// File: rtl/qacc_chk.sv
module qacc_chk #(
    parameter int NQ       = 32,
    parameter int DESC_W   = 32,
    parameter int LIST_MAX = 64,
    parameter int LAT_W    = 16,
    parameter int TICK_DIV = 100,
    localparam int CNT_W   = $clog2(LIST_MAX + 1),
    localparam int ENT_W   = DESC_W + qacc_pkg::QOFF_W
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [1:0]                   cfg_mode,
    input logic                         cfg_multi,
    input logic [qacc_pkg::QOFF_W-1:0]  cfg_single,
    input logic [CNT_W-1:0]             cfg_list_len,
    input logic [LAT_W-1:0]             cfg_latency,
    input logic [NQ-1:0]                q_nonempty,
    input logic                         pop_req,
    input logic [qacc_pkg::QOFF_W-1:0]  pop_qsel,
    input logic                         pop_ack,
    input logic [DESC_W-1:0]            pop_desc,
    input logic                         lst_we,
    input logic [CNT_W-1:0]             lst_idx,
    input logic [ENT_W-1:0]             lst_entry,
    input logic [CNT_W-1:0]             lst_count,
    input logic                         irq,
    input logic                         irq_ack
);
    logic [CNT_W-1:0] eff_len;
    assign eff_len = (cfg_list_len == '0) ? CNT_W'(1) : cfg_list_len;

    assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !cfg_multi) |-> (pop_qsel == cfg_single));

    assert_idx_follows_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lst_we |-> (lst_count == lst_idx + 1'b1));

    assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !pop_ack) |=> (pop_req && $stable(pop_qsel)));

    assert_below_len_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (lst_count < eff_len));

    assert_no_pop_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !pop_req);

    assert_hold_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> (irq && $stable(lst_count)));

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack) |=> (!irq && (lst_count == '0)));

    assert_full_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && (cfg_mode == 2'd0)) |-> (lst_count >= eff_len));
endmodule

bind qacc_channel qacc_chk #(
    .NQ(NQ), .DESC_W(DESC_W), .LIST_MAX(LIST_MAX), .LAT_W(LAT_W), .TICK_DIV(TICK_DIV)
) i_chk (.*);

// File: tb/test_qacc_channel.sv
module test_qacc_channel;
    localparam int NQ   = 32;
    localparam int DW   = 32;
    localparam int LMAX = 16;
    localparam int LW   = 8;
    localparam int TD   = 4;
    localparam int CW   = $clog2(LMAX + 1);
    localparam int EW   = DW + 5;

    typedef struct {
        logic [EW-1:0] entry;
        int            idx;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mode = '0;
    logic          cfg_multi = 1'b0;
    logic [4:0]    cfg_single = '0;
    logic [CW-1:0] cfg_list_len = '0;
    logic [LW-1:0] cfg_latency = '0;
    logic [NQ-1:0] q_nonempty = '0;
    logic          pop_req;
    logic [4:0]    pop_qsel;
    logic          pop_ack = 1'b0;
    logic [DW-1:0] pop_desc = '0;
    logic          lst_we;
    logic [CW-1:0] lst_idx;
    logic [EW-1:0] lst_entry;
    logic [CW-1:0] lst_count;
    logic          irq;
    logic          irq_ack = 1'b0;

    int    checks = 0;
    int    errors = 0;
    bit    hold = 1'b1;
    int    pops_q9 = 0;
    int    pend_pops = 0;
    int    empty_pops = 0;
    string cur = "R1";
    logic [DW-1:0] qm [NQ][$];
    exp_t  exp_q [$];

    always #5 clk = ~clk;

    qacc_channel #(.NQ(NQ), .DESC_W(DW), .LIST_MAX(LMAX), .LAT_W(LW), .TICK_DIV(TD))
    i_qacc_channel (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_multi(cfg_multi),
        .cfg_single(cfg_single), .cfg_list_len(cfg_list_len), .cfg_latency(cfg_latency),
        .q_nonempty(q_nonempty), .pop_req(pop_req), .pop_qsel(pop_qsel),
        .pop_ack(pop_ack), .pop_desc(pop_desc), .lst_we(lst_we), .lst_idx(lst_idx),
        .lst_entry(lst_entry), .lst_count(lst_count), .irq(irq), .irq_ack(irq_ack)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic void upd_flags();
        for (int i = 0; i < NQ; i++) q_nonempty[i] = !hold && (qm[i].size() != 0);
    endfunction

    // queue manager model: answers a pending pop at the next falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (pop_ack) begin
                pop_ack = 1'b0;
            end else if (rst_n && pop_req) begin
                if (qm[pop_qsel].size() > 0) pop_desc = qm[pop_qsel].pop_front();
                else begin pop_desc = '0; empty_pops++; end
                if (pop_qsel == 5'd9) pops_q9++;
                pop_ack = 1'b1;
                upd_flags();
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && pop_req && irq) pend_pops++;
            if (rst_n && lst_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur, "unexpected list write", longint'(lst_entry), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(lst_entry == e.entry, cur, "list entry", longint'(lst_entry), longint'(e.entry));
                    chk(int'(lst_idx) == e.idx, cur, "list index", longint'(lst_idx), longint'(e.idx));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic restart(input logic [1:0] m, input bit multi, input int sel,
                           input int len, input int lat);
        rst_n = 1'b0;
        hold = 1'b1;
        irq_ack = 1'b0;
        for (int i = 0; i < NQ; i++) qm[i].delete();
        exp_q.delete();
        upd_flags();
        cfg_mode = m;
        cfg_multi = multi;
        cfg_single = 5'(sel);
        cfg_list_len = CW'(len);
        cfg_latency = LW'(lat);
        pops_q9 = 0;
        pend_pops = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic put(input int q, input logic [DW-1:0] d);
        qm[q].push_back(d);
        upd_flags();
    endtask

    task automatic put_s(input int q, input logic [DW-1:0] d, input int idx);
        exp_t e;
        e.entry = {5'(q), d};
        e.idx = idx;
        exp_q.push_back(e);
        put(q, d);
    endtask

    task automatic go();
        hold = 1'b0;
        upd_flags();
    endtask

    // expected round-robin service order, computed from the model queues
    task automatic expect_rr(input int last, input int len);
        logic [DW-1:0] cp [NQ][$];
        int k;
        bit any;
        for (int i = 0; i < NQ; i++) cp[i] = qm[i];
        k = 0;
        any = 1'b1;
        while (any) begin
            any = 1'b0;
            for (int j = 1; j <= NQ; j++) begin
                int q;
                q = (last + j) % NQ;
                if (!any && cp[q].size() > 0) begin
                    exp_t e;
                    e.entry = {5'(q), cp[q].pop_front()};
                    e.idx = k % len;
                    exp_q.push_back(e);
                    last = q;
                    any = 1'b1;
                    k++;
                end
            end
        end
    endtask

    task automatic wait_we();
        int n = 0;
        while (!lst_we && n < 300) begin @(negedge clk); n++; end
        chk(lst_we == 1'b1, cur, "list write seen", longint'(lst_we), 1);
    endtask

    task automatic wait_irq(output int n, input int maxc);
        n = 0;
        while (!irq && n < maxc) begin @(negedge clk); n++; end
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        int n;
        // R1: reset state
        cur = "R1";
        restart(2'd0, 1'b1, 0, 4, 2);
        chk(irq == 1'b0, "R1", "irq after reset", longint'(irq), 0);
        chk(lst_count == '0, "R1", "count after reset", longint'(lst_count), 0);
        chk(pop_req == 1'b0, "R1", "pop_req after reset", longint'(pop_req), 0);
        chk(lst_we == 1'b0, "R1", "lst_we after reset", longint'(lst_we), 0);

        // R2 single queue, R6 no timed interrupt in mode 0
        cur = "R2";
        restart(2'd0, 1'b0, 5, 16, 2);
        put_s(5, 32'hA000_0001, 0);
        put_s(5, 32'hA000_0002, 1);
        put_s(5, 32'hA000_0003, 2);
        put(9, 32'hBAD0_0009);
        put(9, 32'hBAD0_0019);
        go();
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "entries pending", exp_q.size(), 0);
        chk(lst_count == CW'(3), "R2", "count", longint'(lst_count), 3);
        chk(pops_q9 == 0, "R2", "pops of unwatched queue 9", pops_q9, 0);
        cur = "R6";
        repeat (150) @(negedge clk);
        chk(irq == 1'b0, "R6", "mode 0 timed irq", longint'(irq), 0);

        // R3 round robin, R4 full, R5 pending hold and ack
        cur = "R3";
        restart(2'd0, 1'b1, 0, 6, 2);
        put(2, 32'hC000_0021); put(2, 32'hC000_0022);
        put(7, 32'hC000_0071);
        put(30, 32'hC000_0301); put(30, 32'hC000_0302); put(30, 32'hC000_0303);
        put(0, 32'hC000_0001);
        expect_rr(NQ - 1, 6);
        go();
        wait_irq(n, 300);
        chk(irq == 1'b1, "R4", "full irq", longint'(irq), 1);
        chk(lst_we == 1'b1 && lst_idx == CW'(5), "R4", "irq with last write idx",
            longint'(lst_idx), 5);
        chk(lst_count == CW'(6), "R4", "count at full", longint'(lst_count), 6);
        chk(exp_q.size() == 1, "R3", "entries left before ack", exp_q.size(), 1);
        repeat (20) @(negedge clk);
        chk(irq == 1'b1 && lst_count == CW'(6), "R5", "list held while pending",
            longint'(lst_count), 6);
        chk(pend_pops == 0, "R5", "pops while pending", pend_pops, 0);
        ack();
        chk(irq == 1'b0, "R5", "irq after ack", longint'(irq), 0);
        chk(lst_count == '0, "R5", "count after ack", longint'(lst_count), 0);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "accumulation resumed", exp_q.size(), 0);
        chk(lst_count == CW'(1), "R3", "count after resume", longint'(lst_count), 1);
        chk(empty_pops == 0, "R3", "pops of empty queues", empty_pops, 0);

        // R8 mode 2
        cur = "R8";
        restart(2'd2, 1'b0, 3, 16, 5);
        put_s(3, 32'hD000_0003, 0);
        go();
        wait_we();
        wait_irq(n, 500);
        chk(n == 5 * TD, "R8", "cycles from first write to irq", n, 5 * TD);
        ack();

        // R9 mode 3
        cur = "R9";
        restart(2'd3, 1'b0, 3, 16, 5);
        put_s(3, 32'hE000_0001, 0);
        go();
        wait_we();
        repeat (8) @(negedge clk);
        chk(irq == 1'b0, "R9", "no irq before window", longint'(irq), 0);
        put_s(3, 32'hE000_0002, 1);
        wait_we();
        wait_irq(n, 500);
        chk(n == 5 * TD, "R9", "cycles from latest write to irq", n, 5 * TD);
        chk(lst_count == CW'(2), "R9", "count at irq", longint'(lst_count), 2);
        ack();

        // R7 mode 1
        cur = "R7";
        restart(2'd1, 1'b0, 1, 16, 3);
        repeat (40) @(negedge clk);
        chk(irq == 1'b0, "R7", "empty expiry raises nothing", longint'(irq), 0);
        put_s(1, 32'hF000_0001, 0);
        go();
        wait_irq(n, 200);
        chk(irq == 1'b1, "R7", "irq after restarted timer", longint'(irq), 1);
        ack();
        put_s(1, 32'hF000_0002, 0);
        wait_irq(n, 500);
        chk(n == 3 * TD, "R7", "cycles from ack to irq", n, 3 * TD);
        chk(lst_count == CW'(1), "R7", "count at irq", longint'(lst_count), 1);
        ack();

        // R10 zero latency
        cur = "R10";
        restart(2'd2, 1'b0, 4, 16, 0);
        put_s(4, 32'h1234_0004, 0);
        go();
        wait_we();
        wait_irq(n, 500);
        chk(n == TD, "R10", "zero latency window", n, TD);
        ack();

        // R4 zero list length acts as one
        cur = "R4";
        restart(2'd0, 1'b0, 2, 0, 9);
        put_s(2, 32'h5555_0002, 0);
        go();
        wait_we();
        chk(irq == 1'b1, "R4", "irq on first write with length 0", longint'(irq), 1);
        chk(lst_count == CW'(1), "R4", "count with length 0", longint'(lst_count), 1);
        ack();
        repeat (4) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule